// File: doc/BRIEF.md
# Flash Command Interface with Reset Control

This block is the control front end of a NOR-style flash device model. A host writes command bytes by pulling chip-enable and write-enable low together. The block decodes each byte into a read mode, a status operation, or the first half of a two-write erase or program sequence. When a sequence is confirmed and neither lockout nor write protection blocks it, the block starts an operation and reports it through a ready output that stays low while a counter stands in for the array timing engine. Reads made with chip-enable and output-enable low return either the array data presented at `arr_rdata` or a status byte, depending on the latched mode.

A separate active-low reset pin controls power. When it falls during an operation, the operation is aborted. Ready stays low for a fixed abort time, and the block then sleeps in deep power-down. When it falls while the block is idle, the block goes straight to sleep. In both cases the status flags are cleared and the mode returns to read-array. After the pin rises, reads stay invalid for one programmable wake-up time and writes are ignored for another.

Top module: `flash_cmd_if`

## Requirements
- R1: A command byte is taken only on the cycle in which chip-enable and write-enable are first seen low together. A write strobe with either one held high has no effect.
- R2: Erase needs setup byte 0x20 followed by confirm byte 0xD0. Program needs setup byte 0x40 followed by any data byte. A setup byte alone never makes the block busy. A confirmed operation pulses `op_start` for one cycle with `op_erase` and `op_data`, and holds `ready` low for ERASE_CYC cycles (erase) or PROG_CYC cycles (program).
- R3: If erase setup is followed by any byte other than 0xD0, no operation starts, status bit 5 is set, and the mode becomes status-read.
- R4: A confirm made while `vpp_lock` is high sets status bit 3. A confirm made while `wp_n` is low sets status bit 1. In both cases no operation starts. Status bit 7 is the ready flag, and all other status bits read 0.
- R5: After an operation is confirmed, reads return the status byte. They keep doing so after the operation completes, until byte 0xFF restores array reads.
- R6: Byte 0x70 selects status reads. Byte 0x50 clears status bits 5, 3 and 1 and does not change the mode.
- R7: While `supply_lock` is high, the mode is forced to read-array and command writes are ignored.
- R8: If the reset pin falls while an operation runs, the operation is aborted. `ready` stays low for ABORT_CYC cycles, and the block then enters deep power-down with `ready` high. If the pin falls while idle, deep power-down follows on the next cycle.
- R9: A falling reset pin clears the status flags and selects read-array mode. Writes made while the pin is low are ignored.
- R10: After the reset pin rises, `dout_ok` stays low for RD_WAKE cycles, and writes are ignored for WR_WAKE cycles.
- R11: Toggling `vpp_lock` or chip-enable, without a complete write, leaves the mode unchanged.
- R12: After the power-on reset `rst_n` is released, the block is in deep power-down with `ready` high and an empty status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| rst_pin_n | input | 1 | Device reset / deep power-down pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 8 | Command or data byte |
| supply_lock | input | 1 | Supply below lockout level |
| vpp_lock | input | 1 | Program voltage below lockout level |
| wp_n | input | 1 | Write protect, active low |
| arr_rdata | input | 8 | Data from the array model |
| dout | output | 8 | Read data (array or status) |
| dout_ok | output | 1 | Read data valid |
| ready | output | 1 | High when idle, low while busy or aborting |
| deep_pd | output | 1 | Deep power-down active |
| op_start | output | 1 | One-cycle pulse when an operation starts |
| op_erase | output | 1 | Started operation is an erase |
| op_data | output | 8 | Data byte of the started operation |

## Verification
The hardest case to reach is a reset pin that falls while an erase is still counting. To get there, the stimulus issues a confirmed erase, waits part of the busy window, and then drops the pin. It counts the abort cycles, then raises the pin and fires a write into the write wake-up window. Later reads show that the stray write was dropped and that the earlier error flag was cleared. Random program data and random non-command bytes are mixed in to exercise the decoder.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_ESETUP, M_PSETUP} cmd_mode_t;
  typedef enum logic [1:0] {P_ACTIVE, P_ABORT, P_SLEEP} pwr_state_t;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_CLR      = 8'h50;

  // status layout: 7 ready, 5 sequence error, 3 voltage lockout, 1 protected
  function automatic logic [7:0] pack_status(logic rdy, logic seq_e, logic vpp_e, logic wp_e);
    return {rdy, 1'b0, seq_e, 1'b0, vpp_e, 1'b0, wp_e, 1'b0};
  endfunction

  function automatic int op_len(logic erase, int erase_cyc, int prog_cyc);
    return erase ? erase_cyc : prog_cyc;
  endfunction
endpackage

// File: rtl/fci_busy.sv
module fci_busy import fci_pkg::*; #(
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_erase,
  input  logic abort,
  output logic busy
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (abort)      cnt <= '0;
    else if (start)      cnt <= CW'(op_len(is_erase, ERASE_CYC, PROG_CYC));
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !abort |=> busy);
  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
endmodule

// File: rtl/fci_power.sv
module fci_power import fci_pkg::*; #(
  parameter int RD_WAKE   = 4,
  parameter int WR_WAKE   = 2,
  parameter int ABORT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic       busy,
  output pwr_state_t pstate,
  output logic       abort_go,
  output logic       enter_rst,
  output logic       rd_open,
  output logic       wr_open
);
  localparam int RW = $clog2(RD_WAKE + 2);
  localparam int WW = $clog2(WR_WAKE + 2);
  localparam int AW = $clog2(ABORT_CYC + 2);

  logic [RW-1:0] rcnt;
  logic [WW-1:0] wcnt;
  logic [AW-1:0] acnt;

  assign enter_rst = (pstate == P_ACTIVE) && !pin_n;
  assign abort_go  = enter_rst && busy;
  assign rd_open   = (pstate == P_ACTIVE) && (rcnt == '0);
  assign wr_open   = (pstate == P_ACTIVE) && (wcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate <= P_SLEEP;
      rcnt   <= '0;
      wcnt   <= '0;
      acnt   <= '0;
    end else begin
      case (pstate)
        P_ACTIVE: begin
          if (!pin_n) begin
            rcnt <= '0;
            wcnt <= '0;
            if (busy) begin
              pstate <= P_ABORT;
              acnt   <= AW'(ABORT_CYC - 1);
            end else begin
              pstate <= P_SLEEP;
            end
          end else begin
            if (rcnt != '0) rcnt <= rcnt - 1'b1;
            if (wcnt != '0) wcnt <= wcnt - 1'b1;
          end
        end
        P_ABORT: begin
          if (acnt == '0) pstate <= P_SLEEP;
          else            acnt   <= acnt - 1'b1;
        end
        default: begin
          if (pin_n) begin
            pstate <= P_ACTIVE;
            rcnt   <= RW'(RD_WAKE);
            wcnt   <= WW'(WR_WAKE);
          end
        end
      endcase
    end
  end

  // R8
  abort_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == P_ACTIVE) && !pin_n && busy |=> pstate == P_ABORT);
  // R10
  wake_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == P_SLEEP) && pin_n |=> (RD_WAKE == 0) || !rd_open);
  // R10
  wake_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == P_SLEEP) && pin_n |=> (WR_WAKE == 0) || !wr_open);
endmodule

// File: rtl/fci_decode.sv
module fci_decode import fci_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_stb,
  input  logic [7:0] din,
  input  logic      supply_lock,
  input  logic      vpp_lock,
  input  logic      wp_n,
  input  logic      clr_all,
  output cmd_mode_t mode,
  output logic      seq_err,
  output logic      vpp_err,
  output logic      wp_err,
  output logic      go,
  output logic      go_erase,
  output logic      op_start,
  output logic      op_erase,
  output logic [7:0] op_data
);
  logic confirm_hit;

  assign confirm_hit = wr_stb && ((mode == M_PSETUP) ||
                                  ((mode == M_ESETUP) && (din == CMD_CONFIRM)));
  assign go       = confirm_hit && !vpp_lock && wp_n && !clr_all;
  assign go_erase = (mode == M_ESETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_ARRAY;
      seq_err  <= 1'b0;
      vpp_err  <= 1'b0;
      wp_err   <= 1'b0;
      op_start <= 1'b0;
      op_erase <= 1'b0;
      op_data  <= '0;
    end else if (clr_all) begin
      mode     <= M_ARRAY;
      seq_err  <= 1'b0;
      vpp_err  <= 1'b0;
      wp_err   <= 1'b0;
      op_start <= 1'b0;
    end else begin
      op_start <= go;
      if (go) begin
        op_erase <= go_erase;
        op_data  <= din;
      end
      if (supply_lock) begin
        mode <= M_ARRAY;
      end else if (wr_stb) begin
        case (mode)
          M_ESETUP, M_PSETUP: begin
            mode <= M_STATUS;
            if ((mode == M_ESETUP) && (din != CMD_CONFIRM)) seq_err <= 1'b1;
            else if (vpp_lock)                              vpp_err <= 1'b1;
            else if (!wp_n)                                 wp_err  <= 1'b1;
          end
          default: begin
            case (din)
              CMD_RD_ARRAY: mode <= M_ARRAY;
              CMD_RD_STAT:  mode <= M_STATUS;
              CMD_ERASE:    mode <= M_ESETUP;
              CMD_PROG:     mode <= M_PSETUP;
              CMD_CLR: begin
                seq_err <= 1'b0;
                vpp_err <= 1'b0;
                wp_err  <= 1'b0;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  // R9
  clr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (mode == M_ARRAY) && !seq_err && !vpp_err && !wp_err);
  // R7
  supply_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_lock |=> mode == M_ARRAY);
  // R3
  bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !clr_all && !supply_lock && (mode == M_ESETUP) && (din != CMD_CONFIRM)
    |=> seq_err && (mode == M_STATUS));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if import fci_pkg::*; #(
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 5,
  parameter int ABORT_CYC = 3,
  parameter int RD_WAKE   = 4,
  parameter int WR_WAKE   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic [7:0] din,
  input  logic       supply_lock,
  input  logic       vpp_lock,
  input  logic       wp_n,
  input  logic [7:0] arr_rdata,
  output logic [7:0] dout,
  output logic       dout_ok,
  output logic       ready,
  output logic       deep_pd,
  output logic       op_start,
  output logic       op_erase,
  output logic [7:0] op_data
);
  logic       wr_act, wr_act_q, wr_edge, wr_stb;
  logic       busy, go, go_erase, abort_go, enter_rst, rd_open, wr_open;
  logic       seq_err, vpp_err, wp_err;
  cmd_mode_t  mode;
  pwr_state_t pstate;

  assign wr_act  = !ce_n && !we_n;
  assign wr_edge = wr_act && !wr_act_q;
  assign wr_stb  = wr_edge && rst_pin_n && wr_open && !busy && !supply_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

  fci_power #(.RD_WAKE(RD_WAKE), .WR_WAKE(WR_WAKE), .ABORT_CYC(ABORT_CYC)) u_power (
    .clk(clk), .rst_n(rst_n), .pin_n(rst_pin_n), .busy(busy), .pstate(pstate),
    .abort_go(abort_go), .enter_rst(enter_rst), .rd_open(rd_open), .wr_open(wr_open)
  );

  fci_decode u_decode (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .din(din), .supply_lock(supply_lock),
    .vpp_lock(vpp_lock), .wp_n(wp_n), .clr_all(enter_rst), .mode(mode),
    .seq_err(seq_err), .vpp_err(vpp_err), .wp_err(wp_err), .go(go), .go_erase(go_erase),
    .op_start(op_start), .op_erase(op_erase), .op_data(op_data)
  );

  fci_busy #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(go), .is_erase(go_erase), .abort(abort_go), .busy(busy)
  );

  assign ready   = !busy && (pstate != P_ABORT);
  assign deep_pd = (pstate == P_SLEEP);
  assign dout_ok = !ce_n && !oe_n && rd_open && rst_pin_n;
  assign dout    = !dout_ok ? 8'h00 :
                   ((mode == M_ARRAY) && !busy) ? arr_rdata :
                   pack_status(ready, seq_err, vpp_err, wp_err);

  // R1
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(!ce_n && !we_n));
  // R4
  start_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(!vpp_lock && wp_n));
  // R8
  abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == P_ABORT) |-> !ready && !deep_pd);
endmodule

// File: tb/tb_flash_cmd_if.sv
module tb_flash_cmd_if;
  localparam int ERASE_CYC = 12;
  localparam int PROG_CYC  = 5;
  localparam int ABORT_CYC = 3;
  localparam int RD_WAKE   = 4;
  localparam int WR_WAKE   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rst_pin_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0] din = 8'h00, arr_rdata = 8'h00;
  logic supply_lock = 1'b0, vpp_lock = 1'b0, wp_n = 1'b1;
  logic [7:0] dout, op_data;
  logic dout_ok, ready, deep_pd, op_start, op_erase;

  int total = 0, bad = 0;
  logic [7:0] rd_val;
  logic       rd_ok;
  int unsigned seed_sink;

  always #2 clk = ~clk;

  flash_cmd_if #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .ABORT_CYC(ABORT_CYC),
                 .RD_WAKE(RD_WAKE), .WR_WAKE(WR_WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .din(din), .supply_lock(supply_lock), .vpp_lock(vpp_lock), .wp_n(wp_n),
    .arr_rdata(arr_rdata), .dout(dout), .dout_ok(dout_ok), .ready(ready), .deep_pd(deep_pd),
    .op_start(op_start), .op_erase(op_erase), .op_data(op_data)
  );

  function automatic logic [7:0] want_stat(bit rdy, bit s, bit v, bit w);
    return 8'(rdy * 128 + s * 32 + v * 8 + w * 2);
  endfunction

  function automatic bit is_cmd(logic [7:0] b);
    return (b == 8'hFF) || (b == 8'h70) || (b == 8'h50) || (b == 8'h20) || (b == 8'h40);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_raw(logic c, logic w, logic [7:0] b);
    @(negedge clk); ce_n = c; we_n = w; din = b;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] b);
    wr_raw(1'b0, 1'b0, b);
  endtask

  task automatic rd();
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    #1; rd_val = dout; rd_ok = dout_ok;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_chk(logic [7:0] exp, string req);
    rd();
    chk(rd_ok && (rd_val == exp), req, {rd_ok, rd_val}, {1'b1, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_busy(int exp, string req);
    int n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk(n == exp, req, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'h5eed1234);
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R12 reset state
    chk(ready && deep_pd, "R12", {ready, deep_pd}, 2'b11);
    rd();
    chk(!rd_ok, "R12 read in sleep", rd_ok, 0);

    // R10 read wake-up
    arr_rdata = 8'h5A;
    @(negedge clk); rst_pin_n = 1'b1;
    begin
      int n = 0;
      rd();
      while (!rd_ok && n < 50) begin n++; rd(); end
      chk(n == RD_WAKE, "R10 read wake", n, RD_WAKE);
      chk(rd_val == 8'h5A, "R10 array data", rd_val, 8'h5A);
    end
    chk(!deep_pd, "R8 awake", deep_pd, 0);

    // R1 half strobes
    wr_raw(1'b1, 1'b0, 8'h70);
    rd_chk(8'h5A, "R1 ce high");
    wr_raw(1'b0, 1'b1, 8'h70);
    rd_chk(8'h5A, "R1 we high");
    wr(8'h70);
    rd_chk(want_stat(1, 0, 0, 0), "R1 accepted");
    wr(8'hFF);
    rd_chk(8'h5A, "R6 back to array");

    // R2 lone setup then erase confirm
    wr(8'h20);
    idle(3);
    chk(ready, "R2 lone setup idle", ready, 1);
    rd_chk(want_stat(1, 0, 0, 0), "R2 setup reads status");
    wr(8'hD0);
    chk(op_start && op_erase, "R2 erase start", {op_start, op_erase}, 2'b11);
    count_busy(ERASE_CYC, "R2 erase length");
    arr_rdata = 8'h33;
    rd_chk(want_stat(1, 0, 0, 0), "R5 status after erase");
    idle(2);
    rd_chk(want_stat(1, 0, 0, 0), "R5 still status");
    wr(8'hFF);
    rd_chk(8'h33, "R5 array after FF");

    // R2 random program data
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr(8'h40);
      wr(d);
      chk(op_start && !op_erase && (op_data == d), "R2 program start",
          {op_start, op_erase, op_data}, {2'b10, d});
      count_busy(PROG_CYC, "R2 program length");
      rd_chk(want_stat(1, 0, 0, 0), "R5 status after program");
      wr(8'hFF);
    end

    // R3 bad confirm
    wr(8'h20);
    wr(8'h11);
    chk(ready && !op_start, "R3 no op", {ready, op_start}, 2'b10);
    rd_chk(want_stat(1, 1, 0, 0), "R3 seq error");
    wr(8'h50);
    rd_chk(want_stat(1, 0, 0, 0), "R6 clear keeps status mode");

    // R4 lockout and protection
    vpp_lock = 1'b1;
    wr(8'h40); wr(8'h55);
    chk(ready && !op_start, "R4 vpp no op", {ready, op_start}, 2'b10);
    rd_chk(want_stat(1, 0, 1, 0), "R4 vpp flag");
    vpp_lock = 1'b0;
    wr(8'h50);
    wp_n = 1'b0;
    wr(8'h20); wr(8'hD0);
    chk(ready && !op_start, "R4 wp no op", {ready, op_start}, 2'b10);
    rd_chk(want_stat(1, 0, 0, 1), "R4 wp flag");
    wp_n = 1'b1;
    wr(8'h50);

    // R11 vpp / ce toggles
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); vpp_lock = ~vpp_lock; ce_n = ~ce_n;
    end
    @(negedge clk); vpp_lock = 1'b0; ce_n = 1'b1;
    rd_chk(want_stat(1, 0, 0, 0), "R11 status mode kept");
    wr(8'hFF);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); vpp_lock = ~vpp_lock;
    end
    @(negedge clk); vpp_lock = 1'b0;
    rd_chk(8'h33, "R11 array mode kept");

    // R7 supply lockout
    wr(8'h70);
    @(negedge clk); supply_lock = 1'b1;
    rd_chk(8'h33, "R7 forced array");
    wr(8'h70);
    rd_chk(8'h33, "R7 write ignored");
    @(negedge clk); supply_lock = 1'b0;

    // R8 abort in progress, R9 clear, R10 write wake
    wr(8'h20); wr(8'h11);
    wr(8'h20); wr(8'hD0);
    idle(3);
    chk(!ready, "R8 busy before abort", ready, 0);
    @(negedge clk); rst_pin_n = 1'b0;
    @(negedge clk);
    begin
      int n = 0;
      while (!ready && !deep_pd && n < 50) begin n++; @(negedge clk); end
      chk(n == ABORT_CYC, "R8 abort length", n, ABORT_CYC);
    end
    chk(ready && deep_pd, "R8 sleep after abort", {ready, deep_pd}, 2'b11);
    wr(8'h70);
    rd();
    chk(!rd_ok, "R9 no read while pin low", rd_ok, 0);
    @(negedge clk); rst_pin_n = 1'b1;
    wr(8'h70);
    idle(RD_WAKE + 2);
    rd_chk(8'h33, "R10 write in wake window ignored, R9 array mode");
    wr(8'h70);
    rd_chk(want_stat(1, 0, 0, 0), "R9 status cleared");
    wr(8'hFF);

    // R8 idle reset
    @(negedge clk); rst_pin_n = 1'b0;
    @(negedge clk);
    chk(deep_pd && ready, "R8 idle sleep", {deep_pd, ready}, 2'b11);
    @(negedge clk); rst_pin_n = 1'b1;
    idle(RD_WAKE + 2);

    // random non-command bytes in array mode
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (!is_cmd(b)) begin
        arr_rdata = 8'($urandom);
        wr(b);
        chk(ready, "R2 no op from stray byte", ready, 1);
        rd_chk(arr_rdata, "R1 stray byte keeps array");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule